// File: doc/BRIEF.md
# Clock-Buffer Control Slave (Two-Wire Block Protocol)

This block is the serial control port of a clock fan-out device. It listens on a two-wire bus at standard-mode rates, answers only to its own 7-bit address, and uses a block-transfer protocol to reach a small bank of nine register bytes. Two of those bytes do real work. Together they hold one enable bit for each of twelve true/complement output pairs, plus one bit that selects the stronger output drive. Every other byte reads back as zero.

A write begins with the address byte. The master then sends a command byte and a byte-count byte, and the slave acknowledges both and then discards them. The data bytes that follow land on register byte 0, then byte 1, and so on upward. A read returns a byte-count value first and then the register bytes in the same upward order. The read continues until the master withholds its acknowledge. Each START returns the byte pointer to the lowest register.

SCL and SDA are sampled through synchronizers on a system clock that runs at least 16 times faster than SCL. The SDA pin is open-drain, so the block only ever drives it low. An active-low power-down input forces every enable and the drive-select output inactive, whatever the register contents.

Top module: `clkbuf_cfg_slave`

## Requirements
- R1: The slave acknowledges the address bytes 0xD2 (write) and 0xD3 (read), which carry the 7-bit address 1101001. Any other address byte gets no acknowledge, and the slave leaves SDA untouched and changes no register until the next START.
- R2: In a write, the slave acknowledges every byte. The first two bytes after the address (command and byte count) change nothing. The k-th byte after them, counting from 0, is written to register byte k.
- R3: In a read, the first byte returned is 0x09. Register bytes 0, 1, 2 and upward follow in order. Any byte other than 6 and 7, including bytes past 8, reads as 0x00.
- R4: Each START, including a repeated START, resets the byte pointer, so the next transfer begins again at the byte-count slot (read) or at the command slot (write).
- R5: In a read, the slave releases SDA for the master's acknowledge bit. If that bit is high (no acknowledge), the slave stops driving and remains silent until the next START.
- R6: After reset, register byte 6 is 0x8F and byte 7 is 0xFF. This means all twelve pair enables are 1, the drive-select is 0, and SDA is released.
- R7: Bit i of byte 7 enables pair i for i = 0..7. Bits 3..0 of byte 6 enable pairs 8..11, and bit 5 of byte 6 is the drive-select, where 1 means enhanced. Bits 7, 6 and 4 of byte 6 always read 1, 0 and 0, and writes to them are ignored.
- R8: Writes to register bytes other than 6 and 7 have no effect. Those bytes still read 0x00 afterwards.
- R9: While `pwrdn_n` is low, `pair_en` is all zero and `drive_boost` is 0. Register contents are kept, and they return to the outputs when `pwrdn_n` goes high.
- R10: A STOP releases SDA and ends the transfer. SDA is driven low only during a slave acknowledge or while a 0 data bit is being sent.
- R11: A START that arrives partway through a byte abandons that byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| pwrdn_n | input | 1 | Active-low power-down, gates all outputs |
| pair_en | output | 12 | Enable for each output pair (bit i = pair i) |
| drive_boost | output | 1 | Enhanced output drive select |

## Verification
The power-down gate and a register commit can land on the same system clock. A data byte is committed on the SCL falling edge after its eighth bit, and `pwrdn_n` may change on that very cycle. To provoke this, the bench toggles `pwrdn_n` at random, cycle by cycle, across whole random write transfers. Two checks judge the result. Every cycle, a monitor confirms that no enable or drive-select shows while `pwrdn_n` is low. After each STOP, the outputs must equal the bench's own register model gated by the current `pwrdn_n` level, and a readback must match the model exactly.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  localparam int PAIRS    = 12;
  localparam int SLOT_W   = 5;
  localparam int HI_BYTE  = 6;
  localparam int LO_BYTE  = 7;

  localparam logic [7:0] HI_RESET = 8'h8F;
  localparam logic [7:0] LO_RESET = 8'hFF;
  localparam logic [7:0] HI_WMASK = 8'h2F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK
  } bus_st_e;

  function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
    return (&s) ? s : s + 1'b1;
  endfunction

  function automatic logic [7:0] hi_merge(input logic [7:0] d);
    return (d & HI_WMASK) | (HI_RESET & ~HI_WMASK);
  endfunction

endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_ff;
  logic [SYNC_STAGES-1:0] sda_ff;
  logic scl_p, sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[SYNC_STAGES-1];
  assign sda_s = sda_ff[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_p;
  assign scl_fall  = ~scl_s &  scl_p;
  assign start_evt =  scl_s &  scl_p &  sda_p & ~sda_s;
  assign stop_evt  =  scl_s &  scl_p & ~sda_p &  sda_s;

  // R10/R11: bus events are mutually exclusive in any cycle
  p_evt_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_evt, stop_evt}));

endmodule

// File: rtl/cfg_bit_engine.sv
module cfg_bit_engine
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter logic [7:0] BYTE_COUNT = 8'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [7:0]        rd_data,
  output logic [SLOT_W-1:0] rd_idx,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_idx,
  output logic [7:0]        wr_data,
  output logic              sda_oe
);

  bus_st_e           st;
  logic [3:0]        bit_cnt;
  logic [7:0]        sr;
  logic [SLOT_W-1:0] slot;
  logic              is_addr;
  logic              rw_q;
  logic              mack_q;

  logic       byte_done;
  logic       addr_hit;
  logic [7:0] tx_byte;

  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign addr_hit  = (sr[7:1] == SLAVE_ADDR);
  assign rd_idx    = slot - 1'b1;
  assign tx_byte   = (slot == '0) ? BYTE_COUNT : rd_data;

  assign wr_en   = (st == ST_RX) && byte_done && !is_addr && !rw_q &&
                   (slot >= SLOT_W'(2));
  assign wr_idx  = slot - SLOT_W'(2);
  assign wr_data = sr;

  assign sda_oe = (st == ST_RACK) || ((st == ST_TX) && !sr[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      sr      <= '0;
      slot    <= '0;
      is_addr <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_evt) begin
      st      <= ST_RX;
      bit_cnt <= '0;
      slot    <= '0;
      is_addr <= 1'b1;
      rw_q    <= 1'b0;
    end else if (stop_evt) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            sr      <= {sr[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            if (is_addr) begin
              if (addr_hit) begin
                st   <= ST_RACK;
                rw_q <= sr[0];
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              st   <= ST_RACK;
              slot <= slot_next(slot);
            end
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            is_addr <= 1'b0;
            bit_cnt <= '0;
            if (rw_q) begin
              st <= ST_TX;
              sr <= tx_byte;
            end else begin
              st <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            st   <= ST_MACK;
            slot <= slot_next(slot);
          end else if (scl_fall) begin
            sr <= {sr[6:0], 1'b0};
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st      <= ST_TX;
              sr      <= tx_byte;
              bit_cnt <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: a slave acknowledge is only ever entered from a received byte
  p_ack_after_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK && $past(st) != ST_RACK) |-> $past(st) == ST_RX);

  // R10: STOP leaves SDA released
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R3: data is transmitted only in a read transfer
  p_tx_only_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX) |-> rw_q);

  // R11: START always reopens the address phase
  p_start_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_RX && bit_cnt == 4'd0 && is_addr));

  // R2: the bit counter never passes one byte
  p_bitcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd8);

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfgslv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic [PAIRS-1:0]  en_raw,
  output logic              boost_raw
);

  logic [7:0] hi_q;
  logic [7:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= HI_RESET;
      lo_q <= LO_RESET;
    end else if (wr_en) begin
      if (wr_idx == SLOT_W'(HI_BYTE)) hi_q <= hi_merge(wr_data);
      if (wr_idx == SLOT_W'(LO_BYTE)) lo_q <= wr_data;
    end
  end

  always_comb begin
    if (rd_idx == SLOT_W'(HI_BYTE))      rd_data = hi_q;
    else if (rd_idx == SLOT_W'(LO_BYTE)) rd_data = lo_q;
    else                                  rd_data = 8'h00;
  end

  assign en_raw    = {hi_q[3:0], lo_q};
  assign boost_raw = hi_q[5];

  // R8: writes elsewhere leave both live bytes unchanged
  p_ignore_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != SLOT_W'(HI_BYTE) && wr_idx != SLOT_W'(LO_BYTE))
      |=> ($stable(hi_q) && $stable(lo_q)));

  // R7: reserved bits of byte 6 keep their fixed values
  p_reserved_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q[7] && !hi_q[6] && !hi_q[4]));

endmodule

// File: rtl/clkbuf_cfg_slave.sv
module clkbuf_cfg_slave
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter logic [7:0] BYTE_COUNT  = 8'h09,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              pwrdn_n,
  output logic [PAIRS-1:0]  pair_en,
  output logic              drive_boost
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [SLOT_W-1:0] rd_idx, wr_idx;
  logic [7:0] rd_data, wr_data;
  logic wr_en;
  logic [PAIRS-1:0] en_raw;
  logic boost_raw;

  cfg_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  cfg_bit_engine #(.SLAVE_ADDR(SLAVE_ADDR), .BYTE_COUNT(BYTE_COUNT)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfg_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .en_raw(en_raw), .boost_raw(boost_raw)
  );

  generate
    for (genvar g = 0; g < PAIRS; g++) begin : g_gate
      assign pair_en[g] = en_raw[g] & pwrdn_n;
    end
  endgenerate
  assign drive_boost = boost_raw & pwrdn_n;

  // R9: power-down holds every output inactive
  p_pd_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |-> (pair_en == '0 && !drive_boost));

  // R9: leaving power-down restores the stored enables
  p_pd_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_n |-> (pair_en == en_raw));

endmodule

// File: tb/clkbuf_cfg_slave_test.sv
`timescale 1ns/1ps
module clkbuf_cfg_slave_test;

  localparam int Q  = 5;
  localparam int WD = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic pwrdn_n = 1'b1;
  logic pd_rand = 1'b0;
  logic pd_level = 1'b1;
  logic sda_oe;
  logic [11:0] pair_en;
  logic drive_boost;
  logic sda_bus;
  logic oe_seen = 1'b0;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] m_hi = 8'h8F;
  logic [7:0] m_lo = 8'hFF;
  logic [7:0] wbuf [16];

  assign sda_bus = ~(m_low | sda_oe);

  always #2.5 clk = ~clk;

  clkbuf_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pwrdn_n(pwrdn_n), .pair_en(pair_en), .drive_boost(drive_boost)
  );

  function automatic logic [7:0] exp_read(input int slot);
    if (slot == 0) return 8'h09;
    if (slot - 1 == 6) return m_hi;
    if (slot - 1 == 7) return m_lo;
    return 8'h00;
  endfunction

  function automatic logic [12:0] exp_out(input logic pd_n);
    return pd_n ? {m_hi[5], m_hi[3:0], m_lo} : 13'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; qwait();
    scl = 1'b1;   qwait();
    m_low = 1'b1; qwait();
    scl = 1'b0;   qwait();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; qwait();
    scl = 1'b1;   qwait();
    m_low = 1'b0; qwait();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_low = ~b; qwait();
    scl = 1'b1; qwait();
    s = sda_bus; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(~give_ack, s);
  endtask

  // write n data bytes from wbuf; updates the model
  task automatic wr_xact(input int n);
    logic ack;
    i2c_start();
    send_byte(8'hD2, ack); chk("R1 write address ack", ack, 1);
    send_byte(8'($urandom), ack); chk("R2 command ack", ack, 1);
    send_byte(8'($urandom), ack); chk("R2 count ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); chk("R2 data ack", ack, 1);
      if (i == 6) m_hi = {2'b10, wbuf[i][5], 1'b0, wbuf[i][3:0]};
      if (i == 7) m_lo = wbuf[i];
    end
    i2c_stop();
  endtask

  task automatic rd_xact(input int n, input string tag);
    logic ack;
    logic [7:0] d;
    i2c_start();
    send_byte(8'hD3, ack); chk("R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk(tag, d, exp_read(k));
    end
    i2c_stop();
  endtask

  task automatic chk_outputs(input string tag);
    @(negedge clk);
    chk(tag, {drive_boost, pair_en}, exp_out(pwrdn_n));
  endtask

  // power-down driver
  initial begin
    forever begin
      @(posedge clk); #1;
      if (pd_rand) begin
        if ($urandom % 16 == 0) pwrdn_n = ~pwrdn_n;
      end else pwrdn_n = pd_level;
    end
  end

  // R9 monitor and SDA drive monitor
  always @(negedge clk) begin
    if (sda_oe) oe_seen <= 1'b1;
    if (rst_n && !pwrdn_n && (pair_en != 12'h0 || drive_boost)) begin
      compared++;
      mismatched++;
      $display("FAIL R9 gated outputs actual=%0h expected=0", {drive_boost, pair_en});
    end
  end

  initial begin
    repeat (WD) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic ack, s;
    logic [7:0] d;
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state
    chk("R6 reset outputs", {drive_boost, pair_en}, 13'h0FFF);
    chk("R6 reset sda", sda_oe, 0);
    rd_xact(10, "R3 R6 reset readback");

    // R2 R7 directed write across all bytes
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h11 * (i + 1);
    wbuf[6] = 8'hF5;  // reserved bits set, boost on, en 8..11 = 0101
    wbuf[7] = 8'hA3;
    wr_xact(8);
    chk("R7 mapping", {drive_boost, pair_en}, 13'h15A3);
    chk("R7 reserved byte6", m_hi, 8'hA5);
    rd_xact(10, "R8 R7 readback");

    // R1 foreign addresses ignored
    oe_seen = 1'b0;
    i2c_start();
    send_byte(8'hA0, ack); chk("R1 foreign address nack", ack, 0);
    send_byte(8'h00, ack); chk("R1 ignored after nack", ack, 0);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    i2c_stop();
    i2c_start();
    send_byte(8'hD4, ack); chk("R1 near address nack", ack, 0);
    i2c_stop();
    chk("R1 no sda drive", oe_seen, 0);
    chk_outputs("R1 regs untouched");

    // R5 early NACK then fresh read from the start (R4)
    i2c_start();
    send_byte(8'hD3, ack); chk("R1 read ack", ack, 1);
    recv_byte(1'b1, d); chk("R3 first byte count", d, 8'h09);
    recv_byte(1'b0, d); chk("R3 byte0", d, 8'h00);
    oe_seen = 1'b0;
    qwait(); qwait();
    chk("R5 released after nack", oe_seen, 0);
    i2c_stop();
    rd_xact(9, "R4 restart from count");

    // R4 R11 repeated START after data, and partway through a byte
    wbuf[0] = 8'h77; wbuf[1] = 8'h66;
    i2c_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h09, ack);
    send_byte(wbuf[0], ack); chk("R2 ack before restart", ack, 1);
    clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    i2c_start();
    send_byte(8'hD3, ack); chk("R11 restart address ack", ack, 1);
    recv_byte(1'b0, d); chk("R11 R4 count after restart", d, 8'h09);
    i2c_stop();
    chk_outputs("R11 partial byte no write");

    // R8 writes past byte 8 ignored
    for (int i = 0; i < 12; i++) wbuf[i] = 8'hFF;
    wbuf[6] = 8'h00; wbuf[7] = 8'h0F;
    wr_xact(12);
    chk_outputs("R8 long write");
    rd_xact(12, "R8 R3 bytes beyond 8");

    // R9 power-down, writes retained while down
    pd_level = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 pd outputs", {drive_boost, pair_en}, 13'h0);
    wbuf[6] = 8'h2C; wbuf[7] = 8'h5A;
    wr_xact(8);
    chk("R9 pd after write", {drive_boost, pair_en}, 13'h0);
    pd_level = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 restore", {drive_boost, pair_en}, 13'h1C5A);

    // random phase: pd toggling across write commits
    for (int t = 0; t < 24; t++) begin
      int n;
      n = $urandom % 11;
      for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
      pd_rand = 1'b1;
      wr_xact(n);
      chk_outputs("R2 R7 R9 random write");
      pd_rand = 1'b0;
      if (t % 4 == 3) rd_xact(1 + ($urandom % 10), "R3 random readback");
    end
    pd_level = 1'b1;
    repeat (3) @(negedge clk);
    chk_outputs("R10 final outputs");
    chk("R10 final sda", sda_oe, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule